// File: doc/BRIEF.md
# Multithreaded Expression Core Issue Arbiter

This block is the issue stage of a cluster of small multithreaded expression-evaluation cores. Each core holds a fixed number of hardware thread slots. Every cycle each core looks at which of its slots present a ready instruction and issues at most one of them. The choice uses fixed priority, with the lowest slot number winning. Simple operations go straight to the core's own pipelined local units. Long operations, such as divide, logarithm, exponent or float-to-integer conversion, need the one complex-operation block shared by the whole cluster.

Cores that want the shared block raise a request. A round-robin arbiter picks one winner per cycle. A core that loses keeps its request for the next cycle, and in the meantime it may issue a lower-priority slot's local instruction. A slot that wins the shared block is parked: it is skipped by selection until the shared block returns a result tag carrying its core and slot number. The shared block is modelled as a fixed-latency pipe that carries only those tags.

Top module: `ica_cluster`

## Requirements
- R1: After reset no slot is parked and the round-robin pointer is at core 0. Until inputs arrive, all issue and tag outputs are low.
- R2: Each core issues on its local port the lowest-numbered slot that is ready, not parked and not marking a complex operation. The port shows that slot's number and instruction word in the same cycle. The local issue is suppressed only when the core wins the shared block that cycle.
- R3: A core never issues a local instruction in the same cycle that it is granted the shared block.
- R4: A core requests the shared block exactly when its highest-priority ready, unparked slot marks a complex operation. At most one core is granted per cycle, and only a requesting core. The grant port shows the core number, the slot number and the slot's instruction word.
- R5: The grant goes to the first requesting core found by counting upward from the pointer, wrapping past the last core. After a grant the pointer moves to the core after the winner, wrapping to 0. In a cycle with no grant the pointer keeps its value.
- R6: A core that requests and loses issues its highest-priority local-capable slot in the same cycle, if it has one. It requests again in the next cycle.
- R7: A granted slot is parked from the next cycle on and is never issued while parked. The other slots of the same core keep issuing.
- R8: The result tag (core number, slot number) appears on the tag port exactly CX_LAT cycles after the grant cycle. The slot becomes eligible again in the cycle after its tag appears.
- R9: A slot whose ready input is low is never issued on either port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_req | input | NCORES*NTHR | Ready flag per slot; slot t of core c at bit c*NTHR+t |
| thr_cplx | input | NCORES*NTHR | Slot's instruction needs the shared complex block (1) or a local unit (0) |
| thr_instr | input | NCORES*NTHR*IW | Instruction word per slot, slot index s at bits s*IW +: IW |
| loc_vld | output | NCORES | Local issue strobe per core |
| loc_thr | output | NCORES*TW | Slot number issued locally, per core |
| loc_instr | output | NCORES*IW | Instruction word issued locally, per core |
| cx_vld | output | 1 | Shared block accepts an operation this cycle |
| cx_core | output | CW | Core granted the shared block |
| cx_thr | output | TW | Slot of the granted core |
| cx_instr | output | IW | Instruction word sent to the shared block |
| res_vld | output | 1 | Result tag returning from the shared block |
| res_core | output | CW | Core number carried by the tag |
| res_thr | output | TW | Slot number carried by the tag |

## Verification
Issue and grant decisions are combinational, so the bench checks them in the same cycle as the stimulus, sampling late in the cycle just before the edge. Effects that pass through registers are checked in the cycle after the edge that loads them: parking, pointer movement and release of a parked slot. A bench-side delay line of CX_LAT stages predicts each tag, so the tag check lands exactly CX_LAT cycles after the grant it belongs to. Core 0 is driven through every combination of ready and complex flags, and random traffic then exercises contention, parking and the pointer wrapping past the last core.

// File: rtl/ica_pkg.sv
package ica_pkg;
  // Next index in a ring of n entries.
  function automatic int wrap_next(input int i, input int n);
    return (i + 1 >= n) ? 0 : i + 1;
  endfunction
endpackage

// File: rtl/ica_thread_sel.sv
module ica_thread_sel #(
  parameter int NT = 4,
  parameter int IW = 16,
  localparam int TW = $clog2(NT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NT-1:0]    req,
  input  logic [NT-1:0]    cplx,
  input  logic [NT*IW-1:0] instr,
  input  logic             cx_gnt,
  input  logic             tag_vld,
  input  logic [TW-1:0]    tag_thr,
  output logic             cx_req,
  output logic [TW-1:0]    cx_thr,
  output logic [IW-1:0]    cx_instr,
  output logic             loc_vld,
  output logic [TW-1:0]    loc_thr,
  output logic [IW-1:0]    loc_instr
);
  // {found, index} of the lowest set bit
  function automatic logic [TW:0] pick_first(input logic [NT-1:0] v);
    pick_first = '0;
    for (int i = NT - 1; i >= 0; i--)
      if (v[i]) pick_first = {1'b1, TW'(i)};
  endfunction

  logic [NT-1:0] wait_q, wait_d;
  logic [NT-1:0] elig, loc_cand;
  logic [TW:0]   top_pick, loc_pick;
  logic          top_is_cx, cx_win;

  assign elig      = req & ~wait_q;
  assign loc_cand  = elig & ~cplx;
  assign top_pick  = pick_first(elig);
  assign loc_pick  = pick_first(loc_cand);
  assign top_is_cx = top_pick[TW] && cplx[top_pick[TW-1:0]];

  assign cx_req    = top_is_cx;
  assign cx_thr    = top_pick[TW-1:0];
  assign cx_instr  = instr[int'(cx_thr)*IW +: IW];
  assign cx_win    = cx_req && cx_gnt;

  assign loc_vld   = loc_pick[TW] && !cx_win;
  assign loc_thr   = loc_pick[TW-1:0];
  assign loc_instr = instr[int'(loc_thr)*IW +: IW];

  always_comb begin
    wait_d = wait_q;
    for (int t = 0; t < NT; t++) begin
      if (cx_win && cx_thr == TW'(t))        wait_d[t] = 1'b1;
      else if (tag_vld && tag_thr == TW'(t)) wait_d[t] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) wait_q <= '0;
    else        wait_q <= wait_d;
  end

  AST_ONE_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    !(loc_vld && cx_win)); // R3
  AST_LOCAL_ELIG: assert property (@(posedge clk) disable iff (!rst_n)
    loc_vld |-> (req[loc_thr] && !wait_q[loc_thr] && !cplx[loc_thr])); // R2
  AST_PARK_AFTER_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    cx_win |=> wait_q[$past(cx_thr)]); // R7
  AST_TAG_FOR_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    tag_vld |-> wait_q[tag_thr]); // R8
endmodule

// File: rtl/ica_rr_arb.sv
module ica_rr_arb #(
  parameter int N = 6,
  localparam int CW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic          gnt_vld,
  output logic [CW-1:0] gnt_idx
);
  // {found, index} of first request at or after the pointer
  function automatic logic [CW:0] rr_pick(input logic [N-1:0] r, input logic [CW-1:0] p);
    rr_pick = '0;
    for (int k = N - 1; k >= 0; k--) begin
      int j;
      j = (int'(p) + k) % N;
      if (r[j]) rr_pick = {1'b1, CW'(j)};
    end
  endfunction

  logic [CW-1:0] ptr_q, ptr_d;
  logic [CW:0]   pick;

  assign pick    = rr_pick(req, ptr_q);
  assign gnt_vld = pick[CW];
  assign gnt_idx = pick[CW-1:0];

  always_comb begin
    gnt = '0;
    if (gnt_vld) gnt[gnt_idx] = 1'b1;
  end

  assign ptr_d = gnt_vld ? CW'(ica_pkg::wrap_next(int'(gnt_idx), N)) : ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)); // R4
  AST_GNT_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0); // R4
  AST_PTR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !gnt_vld |=> $stable(ptr_q)); // R5
  AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld |=> ptr_q == (($past(gnt_idx) == CW'(N - 1)) ? '0 : $past(gnt_idx) + 1'b1)); // R5
endmodule

// File: rtl/ica_cx_pipe.sv
module ica_cx_pipe #(
  parameter int LAT = 4,
  parameter int CW  = 3,
  parameter int TW  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic [CW-1:0] in_core,
  input  logic [TW-1:0] in_thr,
  output logic          out_vld,
  output logic [CW-1:0] out_core,
  output logic [TW-1:0] out_thr
);
  logic          vld_q  [LAT];
  logic [CW-1:0] core_q [LAT];
  logic [TW-1:0] thr_q  [LAT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < LAT; s++) begin
        vld_q[s]  <= 1'b0;
        core_q[s] <= '0;
        thr_q[s]  <= '0;
      end
    end else begin
      vld_q[0]  <= in_vld;
      core_q[0] <= in_core;
      thr_q[0]  <= in_thr;
      for (int s = 1; s < LAT; s++) begin
        vld_q[s]  <= vld_q[s-1];
        core_q[s] <= core_q[s-1];
        thr_q[s]  <= thr_q[s-1];
      end
    end
  end

  assign out_vld  = vld_q[LAT-1];
  assign out_core = core_q[LAT-1];
  assign out_thr  = thr_q[LAT-1];

  AST_STAGE0_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> vld_q[0]); // R8
endmodule

// File: rtl/ica_cluster.sv
module ica_cluster #(
  parameter int NCORES = 6,
  parameter int NTHR   = 4,
  parameter int IW     = 16,
  parameter int CX_LAT = 4,
  localparam int CW = $clog2(NCORES),
  localparam int TW = $clog2(NTHR),
  localparam int NS = NCORES * NTHR
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NS-1:0]        thr_req,
  input  logic [NS-1:0]        thr_cplx,
  input  logic [NS*IW-1:0]     thr_instr,
  output logic [NCORES-1:0]    loc_vld,
  output logic [NCORES*TW-1:0] loc_thr,
  output logic [NCORES*IW-1:0] loc_instr,
  output logic                 cx_vld,
  output logic [CW-1:0]        cx_core,
  output logic [TW-1:0]        cx_thr,
  output logic [IW-1:0]        cx_instr,
  output logic                 res_vld,
  output logic [CW-1:0]        res_core,
  output logic [TW-1:0]        res_thr
);
  logic [NCORES-1:0] core_req, core_gnt;
  logic [TW-1:0]     core_cx_thr   [NCORES];
  logic [IW-1:0]     core_cx_instr [NCORES];
  logic              gnt_vld;
  logic [CW-1:0]     gnt_idx;

  for (genvar c = 0; c < NCORES; c++) begin : g_core
    logic tag_hit;
    assign tag_hit = res_vld && (res_core == CW'(c));
    ica_thread_sel #(.NT(NTHR), .IW(IW)) u_sel (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (thr_req[c*NTHR +: NTHR]),
      .cplx      (thr_cplx[c*NTHR +: NTHR]),
      .instr     (thr_instr[c*NTHR*IW +: NTHR*IW]),
      .cx_gnt    (core_gnt[c]),
      .tag_vld   (tag_hit),
      .tag_thr   (res_thr),
      .cx_req    (core_req[c]),
      .cx_thr    (core_cx_thr[c]),
      .cx_instr  (core_cx_instr[c]),
      .loc_vld   (loc_vld[c]),
      .loc_thr   (loc_thr[c*TW +: TW]),
      .loc_instr (loc_instr[c*IW +: IW])
    );
  end

  ica_rr_arb #(.N(NCORES)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (core_req),
    .gnt     (core_gnt),
    .gnt_vld (gnt_vld),
    .gnt_idx (gnt_idx)
  );

  assign cx_vld   = gnt_vld;
  assign cx_core  = gnt_idx;
  assign cx_thr   = core_cx_thr[gnt_idx];
  assign cx_instr = core_cx_instr[gnt_idx];

  ica_cx_pipe #(.LAT(CX_LAT), .CW(CW), .TW(TW)) u_pipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vld   (cx_vld),
    .in_core  (cx_core),
    .in_thr   (cx_thr),
    .out_vld  (res_vld),
    .out_core (res_core),
    .out_thr  (res_thr)
  );

  AST_CX_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    cx_vld |-> (core_req[cx_core] && thr_req[int'(cx_core)*NTHR + int'(cx_thr)])); // R9
  AST_CX_NO_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    cx_vld |-> !loc_vld[cx_core]); // R3
endmodule

// File: tb/tb_ica_cluster.sv
`timescale 1ns/100ps
module tb_ica_cluster;
  localparam int NC = 3, NT = 4, IW = 4, LAT = 3;
  localparam int CW = $clog2(NC), TW = $clog2(NT), NS = NC * NT;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NS-1:0] thr_req = '0, thr_cplx = '0;
  logic [NS*IW-1:0] thr_instr = '0;
  logic [NC-1:0] loc_vld;
  logic [NC*TW-1:0] loc_thr;
  logic [NC*IW-1:0] loc_instr;
  logic cx_vld, res_vld;
  logic [CW-1:0] cx_core, res_core;
  logic [TW-1:0] cx_thr, res_thr;
  logic [IW-1:0] cx_instr;

  always #2.5 clk = ~clk;

  ica_cluster #(.NCORES(NC), .NTHR(NT), .IW(IW), .CX_LAT(LAT)) dut (
    .clk(clk), .rst_n(rst_n), .thr_req(thr_req), .thr_cplx(thr_cplx), .thr_instr(thr_instr),
    .loc_vld(loc_vld), .loc_thr(loc_thr), .loc_instr(loc_instr),
    .cx_vld(cx_vld), .cx_core(cx_core), .cx_thr(cx_thr), .cx_instr(cx_instr),
    .res_vld(res_vld), .res_core(res_core), .res_thr(res_thr));

  int checks = 0, fails = 0;
  bit done = 0;
  // reference state
  bit park [NC][NT];
  int ptr;
  bit pv [LAT];
  int pc [LAT], pt [LAT];
  // per-cycle predictions
  int g_core, g_thr;
  int top [NC], lp [NC];
  bit rq [NC];

  task automatic chk(input bit ok, input string rid, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", rid, act, exp);
    end
  endtask

  function automatic int slot_instr(input int c, input int t);
    return int'(thr_instr[(c*NT + t)*IW +: IW]);
  endfunction

  task automatic predict_and_check();
    for (int c = 0; c < NC; c++) begin
      top[c] = -1; lp[c] = -1;
      for (int t = NT - 1; t >= 0; t--) begin
        if (thr_req[c*NT+t] && !park[c][t]) begin
          top[c] = t;
          if (!thr_cplx[c*NT+t]) lp[c] = t;
        end
      end
      rq[c] = (top[c] >= 0) && thr_cplx[c*NT+top[c]];
    end
    g_core = -1; g_thr = 0;
    for (int k = 0; k < NC; k++) begin
      int j;
      j = (ptr + k) % NC;
      if (g_core < 0 && rq[j]) g_core = j;
    end
    if (g_core >= 0) g_thr = top[g_core];
    // R4 / R5: grant
    chk(cx_vld == (g_core >= 0), "R4", int'(cx_vld), int'(g_core >= 0));
    if (g_core >= 0 && cx_vld) begin
      chk(int'(cx_core) == g_core, (rq[(g_core+1)%NC] || rq[(g_core+2)%NC]) ? "R5" : "R4", int'(cx_core), g_core);
      chk(int'(cx_thr) == g_thr, "R4", int'(cx_thr), g_thr);
      chk(int'(cx_instr) == slot_instr(g_core, g_thr), "R4", int'(cx_instr), slot_instr(g_core, g_thr));
    end
    for (int c = 0; c < NC; c++) begin
      bit ev, anypark;
      string rid;
      ev = (lp[c] >= 0) && (g_core != c);
      anypark = 0;
      for (int t = 0; t < NT; t++) anypark |= park[c][t];
      rid = (rq[c] && g_core != c) ? "R6" : (anypark ? "R7" : "R2");
      chk(loc_vld[c] == ev, rid, int'(loc_vld[c]), int'(ev));
      if (ev && loc_vld[c]) begin
        int at;
        at = int'(loc_thr[c*TW +: TW]);
        chk(at == lp[c], rid, at, lp[c]);
        chk(int'(loc_instr[c*IW +: IW]) == slot_instr(c, lp[c]), "R2", int'(loc_instr[c*IW +: IW]), slot_instr(c, lp[c]));
        chk(thr_req[c*NT+at] == 1'b1, "R9", int'(thr_req[c*NT+at]), 1);
      end
      chk(!(loc_vld[c] && cx_vld && int'(cx_core) == c), "R3", int'(loc_vld[c]), 0);
    end
    // R8: tag due LAT cycles after grant
    chk(res_vld == pv[LAT-1], "R8", int'(res_vld), int'(pv[LAT-1]));
    if (pv[LAT-1] && res_vld) begin
      chk(int'(res_core) == pc[LAT-1], "R8", int'(res_core), pc[LAT-1]);
      chk(int'(res_thr) == pt[LAT-1], "R8", int'(res_thr), pt[LAT-1]);
    end
  endtask

  task automatic update_model();
    if (pv[LAT-1]) park[pc[LAT-1]][pt[LAT-1]] = 0;
    if (g_core >= 0) begin
      park[g_core][g_thr] = 1;
      ptr = (g_core + 1) % NC;
    end
    for (int s = LAT - 1; s > 0; s--) begin
      pv[s] = pv[s-1]; pc[s] = pc[s-1]; pt[s] = pt[s-1];
    end
    pv[0] = (g_core >= 0); pc[0] = g_core; pt[0] = g_thr;
  endtask

  task automatic cycle(input logic [NS-1:0] rq_v, input logic [NS-1:0] cx_v);
    @(negedge clk);
    thr_req = rq_v; thr_cplx = cx_v;
    for (int s = 0; s < NS; s++) thr_instr[s*IW +: IW] = IW'($urandom);
    #1.5;
    predict_and_check();
    @(posedge clk);
    update_model();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finish_run();
    end
  end

  initial begin
    ptr = 0;
    for (int c = 0; c < NC; c++) for (int t = 0; t < NT; t++) park[c][t] = 0;
    for (int s = 0; s < LAT; s++) begin pv[s] = 0; pc[s] = 0; pt[s] = 0; end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1.5;
    // R1: idle outputs after reset
    chk(loc_vld == '0, "R1", int'(loc_vld), 0);
    chk(cx_vld == 1'b0, "R1", int'(cx_vld), 0);
    chk(res_vld == 1'b0, "R1", int'(res_vld), 0);
    // R1: all cores request complex on slot 0 with local slot 1; pointer at core 0
    @(negedge clk);
    thr_req = {NC{4'b0011}}; thr_cplx = {NC{4'b0001}};
    #1.5;
    chk(cx_vld && cx_core == '0, "R1", int'(cx_core), 0);
    @(posedge clk);
    // rejoin the reference flow from this point
    g_core = 0; g_thr = 0;
    update_model();
    // contention: pointer rotation, parking and tag return
    for (int i = 0; i < 20; i++) cycle({NC{4'b0111}}, {NC{4'b0101}});
    // near-exhaustive sweep of core 0 flag combinations
    for (int p = 0; p < 256; p++) cycle({8'hA5, p[3:0]}, {8'h3C, p[7:4]});
    for (int p = 0; p < 256; p++) cycle({8'hFF, p[7:4]}, {8'hFF, p[3:0]});
    // random traffic
    for (int i = 0; i < 4000; i++) cycle(NS'($urandom), NS'($urandom));
    // drain outstanding tags with nothing ready (R9: no issue)
    for (int i = 0; i < LAT + 2; i++) cycle('0, '0);
    done = 1;
    finish_run();
  end
endmodule